// File: doc/BRIEF.md
# LIN Transceiver Mode and Bus Wake Controller

This block chooses the operating state of a LIN transceiver. It uses the chip's 2-bit system mode code and a standby-control bit. While the transceiver sits in its low-power state, the block also watches the sampled bus level for a remote wake-up request. The bus level is dominant when low. It first passes through a two-flop synchronizer. A three-sample majority vote then removes short transients. A counter paced by a timebase tick input qualifies how long the bus has been dominant. A wake is reported as a single-clock pulse once the bus has stayed dominant for `WAKE_TICKS` ticks.

The state machine has three states:

- **OFF** (code 0): the transceiver is fully powered down and wake detection is disabled.
- **LOWPWR** (code 1): the transmitter and receiver are disabled and wake detection is armed.
- **ACTIVE** (code 2): the transmitter and receiver are enabled.

The next state comes only from the inputs, so every state can reach every other state in one clock. The transitions are:

- **GO_ACTIVE**: mode code 10 or 11.
- **GO_LOWPWR**: mode code 00 or 01 with standby-control 1.
- **GO_OFF**: mode code 00 or 01 with standby-control 0.

Top module: `lin_xcvr_modectl`

## Requirements
- R1: After reset the state output is OFF (code 0), the transmit/receive enable is 0 and no wake pulse is present.
- R2: With mode code 00 (standby) or 01 (sleep) and standby-control 1, the state becomes LOWPWR (code 1) on the next clock and the transmit/receive enable is 0.
- R3: With mode code 00 or 01 and standby-control 0, the state becomes OFF (code 0) on the next clock, and no wake pulse is produced however long the bus stays dominant.
- R4: With mode code 10 or 11 the state becomes ACTIVE (code 2) on the next clock with the transmit/receive enable at 1, and no wake pulse is produced.
- R5: In LOWPWR, a dominant (low) bus level lasting fewer than `WAKE_TICKS` ticks (default 30) produces no wake pulse.
- R6: In LOWPWR, a dominant bus level held past `WAKE_TICKS` ticks produces exactly one wake pulse, one clock wide. The pulse comes no earlier than `WAKE_TICKS` clocks after the dominant level begins.
- R7: After a wake pulse no further pulse occurs while the bus stays dominant. Once the bus returns recessive (high), a new qualifying dominant period produces a new pulse.
- R8: Isolated one-clock dominant glitches are removed by the majority filter and never advance the wake count.
- R9: Dominant time is counted only on clocks where the tick input is 1. With the tick held at 0, no wake pulse occurs.
- R10: Leaving LOWPWR clears the dominant count, so partial dominant periods on either side of an ACTIVE interval do not add up to a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | System mode code (00 standby, 01 sleep, others run) |
| stby_ctl_i | input | 1 | Standby control: 1 selects LOWPWR, 0 selects OFF |
| bus_rx_i | input | 1 | Sampled bus level, 0 = dominant |
| tick_i | input | 1 | Timebase enable for the dominant counter |
| xcvr_state_o | output | 2 | Transceiver state: 0 OFF, 1 LOWPWR, 2 ACTIVE |
| rxtx_en_o | output | 1 | Transmitter/receiver enable |
| bus_wake_o | output | 1 | One-clock bus wake pulse |

## Verification
The bench targets the count boundary. A dominant run well under the threshold must stay silent, while a held run must give one pulse no sooner than the threshold. An off-by-one or free-running counter would pulse early or repeatedly. Repeated one-clock glitches would give a false wake if the filter passed single samples. Partial dominant periods split across an ACTIVE interval would wake the block if the count were not cleared on mode exit. The remaining cases are a held tick, which would expose counting on every clock, and long dominance in OFF or ACTIVE, which would expose detection left armed outside LOWPWR.

// File: rtl/lin_xcvr_pkg.sv
package lin_xcvr_pkg;
    typedef enum logic [1:0] {
        XS_OFF    = 2'd0,
        XS_LOWPWR = 2'd1,
        XS_ACTIVE = 2'd2
    } xcvr_state_e;

    localparam logic [1:0] MODE_STANDBY = 2'b00;
    localparam logic [1:0] MODE_SLEEP   = 2'b01;
endpackage

// File: rtl/lin_bus_filter.sv
module lin_bus_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rx_i,
    output logic dom_o
);
    localparam int MAJ = VOTE_TAPS / 2 + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   vote_q;
    logic                   level_q;
    logic                   level_d;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= bus_rx_i;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], bus_rx_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vote_q <= '1;
        else        vote_q <= {vote_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
    end

    always_comb begin
        int ones;
        ones = 0;
        for (int i = 0; i < VOTE_TAPS; i++) ones += int'(vote_q[i]);
        level_d = (ones >= MAJ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b1;
        else        level_q <= level_d;
    end

    assign dom_o = ~level_q;
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
    import lin_xcvr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_i,
    input  logic        stby_ctl_i,
    output xcvr_state_e state_o,
    output logic        rxtx_en_o,
    output logic        wake_arm_o
);
    xcvr_state_e state_q, state_d;

    // next-state decode: GO_ACTIVE, GO_LOWPWR, GO_OFF from any state
    always_comb begin
        unique case (mode_i)
            MODE_STANDBY, MODE_SLEEP: state_d = stby_ctl_i ? XS_LOWPWR : XS_OFF;
            default:                  state_d = XS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        rxtx_en_o  = 1'b0;
        wake_arm_o = 1'b0;
        unique case (state_q)
            XS_ACTIVE: rxtx_en_o  = 1'b1;
            XS_LOWPWR: wake_arm_o = 1'b1;
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/lin_wake_qual.sv
module lin_wake_qual #(
    parameter int WAKE_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic dom_i,
    input  logic tick_i,
    output logic wake_o
);
    localparam int CW = $clog2(WAKE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          spent_q;
    logic          wake_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            spent_q <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            wake_q <= 1'b0;
            if (!arm_i || !dom_i) begin
                cnt_q   <= '0;
                spent_q <= 1'b0;
            end else if (tick_i && !spent_q) begin
                if (cnt_q == LAST) begin
                    cnt_q   <= '0;
                    spent_q <= 1'b1;
                    wake_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign wake_o = wake_q;
endmodule

// File: rtl/lin_xcvr_modectl.sv
module lin_xcvr_modectl
    import lin_xcvr_pkg::*;
#(
    parameter int WAKE_TICKS  = 30,
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       stby_ctl_i,
    input  logic       bus_rx_i,
    input  logic       tick_i,
    output logic [1:0] xcvr_state_o,
    output logic       rxtx_en_o,
    output logic       bus_wake_o
);
    xcvr_state_e st;
    logic        arm;
    logic        dom;

    lin_bus_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_filt (
        .clk(clk), .rst_n(rst_n), .bus_rx_i(bus_rx_i), .dom_o(dom)
    );

    lin_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .stby_ctl_i(stby_ctl_i),
        .state_o(st), .rxtx_en_o(rxtx_en_o), .wake_arm_o(arm)
    );

    lin_wake_qual #(.WAKE_TICKS(WAKE_TICKS)) u_qual (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .dom_i(dom),
        .tick_i(tick_i), .wake_o(bus_wake_o)
    );

    assign xcvr_state_o = st;
endmodule

// File: rtl/lin_xcvr_modectl_chk.sv
module lin_xcvr_modectl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       stby_ctl_i,
    input logic [1:0] xcvr_state_o,
    input logic       rxtx_en_o,
    input logic       bus_wake_o
);
    a_r2_lowpwr_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i[1] && stby_ctl_i) |=> (xcvr_state_o == 2'd1 && !rxtx_en_o));

    a_r3_off_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i[1] && !stby_ctl_i) |=> (xcvr_state_o == 2'd0 && !rxtx_en_o));

    a_r4_active_entry: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i[1] |=> (xcvr_state_o == 2'd2 && rxtx_en_o));

    a_r6_one_clock_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wake_o |=> !bus_wake_o);

    a_r3_wake_only_lowpwr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wake_o |-> ($past(xcvr_state_o) == 2'd1));
endmodule

bind lin_xcvr_modectl lin_xcvr_modectl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .stby_ctl_i(stby_ctl_i),
    .xcvr_state_o(xcvr_state_o), .rxtx_en_o(rxtx_en_o), .bus_wake_o(bus_wake_o)
);

// File: tb/test_lin_xcvr_modectl.sv
module test_lin_xcvr_modectl;
    localparam int TICKS = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       stby = 1'b0;
    logic       bus = 1'b1;
    logic       tick = 1'b1;
    logic [1:0] st;
    logic       en;
    logic       wake;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lin_xcvr_modectl #(.WAKE_TICKS(TICKS)) i_lin_xcvr_modectl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .stby_ctl_i(stby),
        .bus_rx_i(bus), .tick_i(tick), .xcvr_state_o(st),
        .rxtx_en_o(en), .bus_wake_o(wake)
    );

    // {mode, stby, expected state, expected enable}
    localparam logic [5:0] VEC [8] = '{
        {2'b00, 1'b1, 2'd1, 1'b0}, {2'b01, 1'b1, 2'd1, 1'b0},
        {2'b00, 1'b0, 2'd0, 1'b0}, {2'b01, 1'b0, 2'd0, 1'b0},
        {2'b10, 1'b0, 2'd2, 1'b1}, {2'b11, 1'b1, 2'd2, 1'b1},
        {2'b01, 1'b1, 2'd1, 1'b0}, {2'b10, 1'b1, 2'd2, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // run n cycles, count pulses, earliest pulse cycle, and wide pulses
    task automatic watch(input int n, output int pulses, output int first, output int wide);
        logic prev;
        prev = 1'b0;
        pulses = 0; first = -1; wide = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (wake) begin
                pulses++;
                if (first < 0) first = i;
                if (prev) wide++;
            end
            prev = wake;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int p, f, w;
        repeat (3) @(negedge clk);
        check("R1 state", st, 0);
        check("R1 enable", en, 0);
        check("R1 wake", wake, 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[k]) begin
            mode = VEC[k][5:4];
            stby = VEC[k][3];
            @(negedge clk);
            check(VEC[k][2:1] == 2'd1 ? "R2 state" : (VEC[k][2:1] == 2'd0 ? "R3 state" : "R4 state"),
                  st, VEC[k][2:1]);
            check("R2/R4 enable", en, VEC[k][0]);
        end

        // R3: off ignores long dominant
        mode = 2'b00; stby = 1'b0; bus = 1'b0;
        watch(3 * TICKS, p, f, w);
        check("R3 no wake in OFF", p, 0);
        bus = 1'b1; repeat (8) @(negedge clk);

        // R4: active ignores long dominant
        mode = 2'b10; bus = 1'b0;
        watch(3 * TICKS, p, f, w);
        check("R4 no wake in ACTIVE", p, 0);
        bus = 1'b1; repeat (8) @(negedge clk);

        // R5: short dominant in lowpower
        mode = 2'b01; stby = 1'b1; repeat (2) @(negedge clk);
        bus = 1'b0;
        watch(TICKS - 10, p, f, w);
        bus = 1'b1;
        begin int p2, f2, w2; watch(10, p2, f2, w2); p += p2; end
        check("R5 short dominant", p, 0);

        // R6: held dominant, one pulse, not early, one clock wide
        bus = 1'b0;
        watch(2 * TICKS, p, f, w);
        check("R6 pulse count", p, 1);
        check("R6 not early", int'(f > TICKS), 1);
        check("R6 width", w, 0);

        // R7: no repeat while dominant, new pulse after recessive
        watch(3 * TICKS, p, f, w);
        check("R7 no repeat", p, 0);
        bus = 1'b1; repeat (8) @(negedge clk);
        bus = 1'b0;
        watch(2 * TICKS, p, f, w);
        check("R7 rearm", p, 1);
        bus = 1'b1; repeat (8) @(negedge clk);

        // R8: isolated one-clock glitches
        p = 0;
        for (int g = 0; g < 3 * TICKS; g++) begin
            int pp, ff, ww;
            bus = 1'b0; @(negedge clk); if (wake) p++;
            bus = 1'b1; watch(2, pp, ff, ww); p += pp;
        end
        watch(8, f, w, w); p += f;
        check("R8 glitches filtered", p, 0);

        // R9: tick gating
        tick = 1'b0; bus = 1'b0;
        watch(4 * TICKS, p, f, w);
        check("R9 no count without tick", p, 0);
        tick = 1'b1;
        watch(2 * TICKS, p, f, w);
        check("R9 counts with tick", p, 1);
        bus = 1'b1; repeat (8) @(negedge clk);

        // R10: count cleared by leaving lowpower
        bus = 1'b0;
        watch(TICKS - 5, p, f, w);
        mode = 2'b10;
        begin int p2, f2, w2; watch(4, p2, f2, w2); p += p2; end
        mode = 2'b00;
        begin int p2, f2, w2; watch(TICKS - 5, p2, f2, w2); p += p2; end
        check("R10 count cleared", p, 0);
        bus = 1'b1; repeat (8) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule